// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a small load/store processor. Each clock cycle it takes one data-processing operation: a 4-bit operation code, two operands, the carry produced by the operand shifter, a set-flags request and the index of the destination register. At the next clock edge it presents the registered result, a write strobe and the destination index for the register file, along with the updated negative, zero, carry and overflow flags.

The sixteen operation codes fall into three groups. Bitwise operations take their carry from the shifter. Add and subtract operations, including the forms that take a carry in and the forms with swapped operands, compute carry and overflow from the arithmetic. Test and compare operations only set flags and never write a register. The block also holds a saved status word. When a writing operation asks for flags and targets the top register index, that word's flag field is copied into the live flags in place of the normal update, so that a return from an exception can restore status.

Top module: `dp_alu_unit`

## Requirements
- R1: Opcodes 0x0 AND, 0x1 EOR, 0xC ORR, 0xD MOV (second operand), 0xE BIC (a AND NOT b) and 0xF MVN (NOT b) register their result with `wr_en_q` high and `wr_idx_q` equal to `dest_idx`, one cycle after the inputs.
- R2: A bitwise writing operation with `set_flags` high and a destination other than 15 sets N to result bit 31, Z to (result == 0), and C to `shift_carry`. It leaves V unchanged.
- R3: 0x4 ADD gives a+b. 0x5 ADC gives a+b+C. C is the carry out of bit 31, and V is bit 31 of ((a^r)&(b^r)).
- R4: 0x2 SUB gives a-b, 0x3 RSB gives b-a, 0x6 SBC gives a-b-(1-C) and 0x7 RSC gives b-a-(1-C). C is set when the amount subtracted, taken as (subtrahend+1-carry-in) without truncation, is at most the minuend. V is bit 31 of ((l^r)&(~s^r)), where l is the minuend and s the subtrahend.
- R5: 0x8 TST (AND) and 0x9 TEQ (XOR) always set N and Z from the result and C from `shift_carry`, keep V, and never assert `wr_en_q`, whatever the value of `set_flags`.
- R6: 0xA CMP and 0xB CMN always set all four flags as SUB and ADD would, and never assert `wr_en_q` or `restore_q`, even when the destination is 15.
- R7: A writing operation with `set_flags` high and `dest_idx` 15 loads the flags {N,Z,C,V} from bits 31:28 of the saved word and pulses `restore_q`. The result is still written.
- R8: A writing operation with `set_flags` low leaves all four flags unchanged.
- R9: Reset clears the flags, the result, the write strobe, the restore pulse and the saved word to zero.
- R10: `saved_we` loads `saved_wdata` into the saved word at the clock edge. A restore in a later cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, after the shifter |
| shift_carry | input | 1 | Carry out of the operand shifter |
| set_flags | input | 1 | Request a flag update |
| dest_idx | input | 4 | Destination register index |
| saved_we | input | 1 | Load the saved status word |
| saved_wdata | input | 32 | New saved status word |
| result_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Register write strobe |
| wr_idx_q | output | 4 | Registered destination index |
| flags_q | output | 4 | Flags {N,Z,C,V} |
| restore_q | output | 1 | Status restore took place |
| saved_q | output | 32 | Saved status word |

## Verification
The assertions assume that every cycle carries a valid operation and that all inputs are stable and known at the clock edge. After reset, they assume the flags are changed only by the operation of the previous cycle. The bench drives every input on the falling edge, so nothing changes near the sampling edge. Before each vector it runs a CMP and then a flag-setting MOV, so the carry-in and the old V are known. It never writes the saved word in the same cycle as an operation that restores it.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  localparam int CC_W = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cc_t;

  // codes 8..B only touch flags
  function automatic logic op_writes(dp_op_e op);
    logic [3:0] raw;
    raw = op;
    return raw[3:2] != 2'b10;
  endfunction

  function automatic logic op_bitwise(dp_op_e op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic op_test(dp_op_e op);
    return (op == OP_TST) || (op == OP_TEQ);
  endfunction

endpackage

// File: rtl/dpalu_datapath.sv
module dpalu_datapath
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           ar_c,
  output logic           ar_v
);

  localparam int MSB = W - 1;

  // sum with carry out in the top bit
  function automatic logic [W:0] add_full(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  // amount removed = y + 1 - ci, kept one bit wider than the data
  function automatic logic [W:0] sub_amount(logic [W-1:0] y, logic ci);
    return {1'b0, y} + {{W{1'b0}}, 1'b1} - {{W{1'b0}}, ci};
  endfunction

  function automatic logic add_ovf(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] r);
    logic [W-1:0] t;
    t = (x ^ r) & (y ^ r);
    return t[MSB];
  endfunction

  function automatic logic sub_ovf(logic [W-1:0] l, logic [W-1:0] s, logic [W-1:0] r);
    logic [W-1:0] t;
    t = (l ^ r) & (~s ^ r);
    return t[MSB];
  endfunction

  logic [W-1:0] lhs, rhs;
  logic         eff_cin;
  logic         is_sub, is_add;
  logic [W:0]   sum_w, amt_w, dif_w;

  always_comb begin
    is_sub  = 1'b0;
    is_add  = 1'b0;
    lhs     = a;
    rhs     = b;
    eff_cin = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin is_sub = 1'b1; eff_cin = 1'b1; end
      OP_RSB:         begin is_sub = 1'b1; eff_cin = 1'b1; lhs = b; rhs = a; end
      OP_SBC:         begin is_sub = 1'b1; eff_cin = cin; end
      OP_RSC:         begin is_sub = 1'b1; eff_cin = cin; lhs = b; rhs = a; end
      OP_ADD, OP_CMN: begin is_add = 1'b1; end
      OP_ADC:         begin is_add = 1'b1; eff_cin = cin; end
      default:        ;
    endcase
  end

  always_comb begin
    sum_w = add_full(lhs, rhs, eff_cin);
    amt_w = sub_amount(rhs, eff_cin);
    dif_w = {1'b0, lhs} - amt_w;
  end

  always_comb begin
    ar_c = 1'b0;
    ar_v = 1'b0;
    if (is_add) begin
      res  = sum_w[W-1:0];
      ar_c = sum_w[W];
      ar_v = add_ovf(lhs, rhs, sum_w[W-1:0]);
    end else if (is_sub) begin
      res  = dif_w[W-1:0];
      ar_c = (amt_w <= {1'b0, lhs});
      ar_v = sub_ovf(lhs, rhs, dif_w[W-1:0]);
    end else begin
      case (op)
        OP_AND, OP_TST: res = a & b;
        OP_EOR, OP_TEQ: res = a ^ b;
        OP_ORR:         res = a | b;
        OP_MOV:         res = b;
        OP_BIC:         res = a & ~b;
        default:        res = ~b;
      endcase
    end
  end

endmodule

// File: rtl/dpalu_flag_ctrl.sv
module dpalu_flag_ctrl
  import dpalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  dp_op_e           op,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [W-1:0]     res,
  input  logic             ar_c,
  input  logic             ar_v,
  input  logic             shift_carry,
  input  cc_t              cur_cc,
  input  cc_t              saved_cc,
  output cc_t              nxt_cc,
  output logic             do_restore,
  output logic             do_write
);

  localparam logic [IDX_W-1:0] TOP_IDX = {IDX_W{1'b1}};

  logic writes, bitwise, test_op, to_top;

  always_comb begin
    writes  = op_writes(op);
    bitwise = op_bitwise(op);
    test_op = op_test(op);
    to_top  = (dest_idx == TOP_IDX);
  end

  always_comb begin
    nxt_cc     = cur_cc;
    do_restore = 1'b0;
    do_write   = writes;
    if (!writes) begin
      nxt_cc.n = res[W-1];
      nxt_cc.z = (res == '0);
      if (test_op) begin
        nxt_cc.c = shift_carry;
      end else begin
        nxt_cc.c = ar_c;
        nxt_cc.v = ar_v;
      end
    end else if (set_flags) begin
      if (to_top) begin
        do_restore = 1'b1;
        nxt_cc     = saved_cc;
      end else begin
        nxt_cc.n = res[W-1];
        nxt_cc.z = (res == '0);
        nxt_cc.c = bitwise ? shift_carry : ar_c;
        if (!bitwise) nxt_cc.v = ar_v;
      end
    end
  end

endmodule

// File: rtl/dpalu_state.sv
module dpalu_state
  import dpalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     res_d,
  input  logic             we_d,
  input  logic [IDX_W-1:0] idx_d,
  input  cc_t              cc_d,
  input  logic             restore_d,
  input  logic             saved_we,
  input  logic [W-1:0]     saved_wdata,
  output logic [W-1:0]     res_q,
  output logic             we_q,
  output logic [IDX_W-1:0] idx_q,
  output cc_t              cc_q,
  output logic             restore_q,
  output logic [W-1:0]     saved_q
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      we_q      <= 1'b0;
      idx_q     <= '0;
      cc_q      <= '0;
      restore_q <= 1'b0;
      saved_q   <= '0;
      primed    <= 1'b0;
    end else begin
      res_q     <= res_d;
      we_q      <= we_d;
      idx_q     <= idx_d;
      cc_q      <= cc_d;
      restore_q <= restore_d;
      primed    <= 1'b1;
      if (saved_we) saved_q <= saved_wdata;
    end
  end

  AST_RESTORE_SRC: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    restore_q |-> (cc_q == cc_t'($past(saved_q[W-1 -: CC_W])))); // R7

  AST_SAVED_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(saved_we) |-> (saved_q == $past(saved_wdata))); // R10

endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dpalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opcode,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             shift_carry,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic             saved_we,
  input  logic [W-1:0]     saved_wdata,
  output logic [W-1:0]     result_q,
  output logic             wr_en_q,
  output logic [IDX_W-1:0] wr_idx_q,
  output logic [CC_W-1:0]  flags_q,
  output logic             restore_q,
  output logic [W-1:0]     saved_q
);

  dp_op_e       op;
  logic [W-1:0] alu_res;
  logic         alu_c, alu_v;
  cc_t          cc_cur, cc_nxt, cc_saved;
  logic         evt_restore, evt_write;

  assign op       = dp_op_e'(opcode);
  assign cc_saved = cc_t'(saved_q[W-1 -: CC_W]);

  dpalu_datapath #(.W(W)) u_dp (
    .op   (op),
    .a    (op_a),
    .b    (op_b),
    .cin  (cc_cur.c),
    .res  (alu_res),
    .ar_c (alu_c),
    .ar_v (alu_v)
  );

  dpalu_flag_ctrl #(.W(W), .IDX_W(IDX_W)) u_fc (
    .op          (op),
    .set_flags   (set_flags),
    .dest_idx    (dest_idx),
    .res         (alu_res),
    .ar_c        (alu_c),
    .ar_v        (alu_v),
    .shift_carry (shift_carry),
    .cur_cc      (cc_cur),
    .saved_cc    (cc_saved),
    .nxt_cc      (cc_nxt),
    .do_restore  (evt_restore),
    .do_write    (evt_write)
  );

  dpalu_state #(.W(W), .IDX_W(IDX_W)) u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_d       (alu_res),
    .we_d        (evt_write),
    .idx_d       (dest_idx),
    .cc_d        (cc_nxt),
    .restore_d   (evt_restore),
    .saved_we    (saved_we),
    .saved_wdata (saved_wdata),
    .res_q       (result_q),
    .we_q        (wr_en_q),
    .idx_q       (wr_idx_q),
    .cc_q        (cc_cur),
    .restore_q   (restore_q),
    .saved_q     (saved_q)
  );

  assign flags_q = cc_cur;

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_FLAG_ONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(opcode[3:2]) == 2'b10) |-> (!wr_en_q && !restore_q)); // R5 R6

  AST_HOLD_WITHOUT_S: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(opcode[3:2]) != 2'b10 && !$past(set_flags)) |-> $stable(flags_q)); // R8

  AST_BITWISE_KEEP_V: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(opcode) inside {4'h0, 4'h1, 4'hC, 4'hD, 4'hE, 4'hF} && $past(dest_idx) != {IDX_W{1'b1}})
      |-> (flags_q[0] == $past(flags_q[0]))); // R2

  AST_WRITE_INDEX: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    wr_en_q |-> (wr_idx_q == $past(dest_idx))); // R1

endmodule

// File: tb/sim_dp_alu_unit.sv
module sim_dp_alu_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic        s;
    logic [3:0]  d;
    logic        cin;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
  } vec_t;

  // flags written {N,Z,C,V}; prior flags before each row: N0 Z0 C=cin V0
  localparam vec_t TBL [NV] = '{
    '{4'h0, 32'hFF00FF00, 32'h0F0F0F0F, 1'b1, 1'b1, 4'd1, 1'b0, 32'h0F000F00, 1'b1, 4'b0010}, // R1 R2 AND
    '{4'h1, 32'h80000000, 32'h00000000, 1'b0, 1'b1, 4'd1, 1'b0, 32'h80000000, 1'b1, 4'b1000}, // R2 EOR
    '{4'hC, 32'h00000000, 32'h00000000, 1'b1, 1'b1, 4'd3, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R2 ORR
    '{4'hD, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd4, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b0010}, // R8 MOV
    '{4'hE, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 1'b1, 4'd5, 1'b1, 32'hFFFF0000, 1'b1, 4'b1000}, // R1 BIC
    '{4'hF, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd6, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R1 MVN
    '{4'h4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 4'd1, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R3 ADD wrap
    '{4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b1, 4'd1, 1'b0, 32'h80000000, 1'b1, 4'b1001}, // R3 ADD ovf
    '{4'h5, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd1, 1'b1, 32'h00000000, 1'b1, 4'b0110}, // R3 ADC carry
    '{4'h2, 32'h80000000, 32'h00000001, 1'b0, 1'b1, 4'd1, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R4 SUB ovf
    '{4'h2, 32'h00000005, 32'h00000005, 1'b0, 1'b1, 4'd1, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R4 SUB zero
    '{4'h3, 32'h00000005, 32'h00000003, 1'b0, 1'b1, 4'd1, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R4 RSB
    '{4'h6, 32'h00000005, 32'h00000003, 1'b0, 1'b1, 4'd1, 1'b0, 32'h00000001, 1'b1, 4'b0010}, // R4 SBC
    '{4'h6, 32'h00000000, 32'h00000000, 1'b0, 1'b1, 4'd1, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R4 SBC borrow
    '{4'h7, 32'h0000000A, 32'h00000003, 1'b0, 1'b1, 4'd1, 1'b1, 32'hFFFFFFF9, 1'b1, 4'b1000}, // R4 RSC
    '{4'h8, 32'h000000F0, 32'h0000000F, 1'b1, 1'b0, 4'd1, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R5 TST
    '{4'h9, 32'h80000000, 32'h00000000, 1'b0, 1'b0, 4'd1, 1'b0, 32'h80000000, 1'b0, 4'b1000}, // R5 TEQ
    '{4'hA, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 4'd15,1'b0, 32'hFFFFFFFF, 1'b0, 4'b1000}, // R6 CMP
    '{4'hB, 32'h80000000, 32'h80000000, 1'b0, 1'b1, 4'd1, 1'b0, 32'h00000000, 1'b0, 4'b0111}, // R6 CMN
    '{4'h4, 32'h00000002, 32'h00000003, 1'b0, 1'b1, 4'd15,1'b0, 32'h00000005, 1'b1, 4'b1010}, // R7 restore
    '{4'h5, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 4'd2, 1'b1, 32'h00000003, 1'b1, 4'b0010}  // R8 ADC hold
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        shift_carry = 1'b0, set_flags = 1'b0;
  logic [3:0]  dest_idx = '0;
  logic        saved_we = 1'b0;
  logic [31:0] saved_wdata = '0;
  logic [31:0] result_q;
  logic        wr_en_q;
  logic [3:0]  wr_idx_q;
  logic [3:0]  flags_q;
  logic        restore_q;
  logic [31:0] saved_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu_unit u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .shift_carry(shift_carry), .set_flags(set_flags), .dest_idx(dest_idx),
    .saved_we(saved_we), .saved_wdata(saved_wdata), .result_q(result_q),
    .wr_en_q(wr_en_q), .wr_idx_q(wr_idx_q), .flags_q(flags_q),
    .restore_q(restore_q), .saved_q(saved_q)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on the falling edge, sample just after the next rising edge
  task automatic issue(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic sc, logic s, logic [3:0] d);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc; set_flags = s; dest_idx = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 result", result_q, 32'h0);
    check("R9 write", {31'b0, wr_en_q}, 32'h0);
    check("R9 flags", {28'b0, flags_q}, 32'h0);
    check("R9 restore", {31'b0, restore_q}, 32'h0);
    check("R9 saved", saved_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    saved_we = 1'b1; saved_wdata = 32'hA000_0000;
    @(negedge clk);
    saved_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(4'hA, 32'h0, 32'h0, 1'b0, 1'b1, 4'd0);
      issue(4'hD, 32'h0, 32'h1, TBL[i].cin, 1'b1, 4'd0);
      issue(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].sc, TBL[i].s, TBL[i].d);
      if (TBL[i].we) begin
        check($sformatf("R1 R3 R4 result row %0d", i), result_q, TBL[i].res);
        check($sformatf("R1 index row %0d", i), {28'b0, wr_idx_q}, {28'b0, TBL[i].d});
      end
      check($sformatf("R1 R5 R6 write row %0d", i), {31'b0, wr_en_q}, {31'b0, TBL[i].we});
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 flags row %0d", i), {28'b0, flags_q}, {28'b0, TBL[i].fl});
      check($sformatf("R6 R7 restore row %0d", i), {31'b0, restore_q},
            {31'b0, TBL[i].we & TBL[i].s & (TBL[i].d == 4'd15)});
    end

    // R10: new saved word, then a restore via MOV
    @(negedge clk);
    opcode = 4'hA; op_a = '0; op_b = '0; set_flags = 1'b0;
    saved_we = 1'b1; saved_wdata = 32'h5000_0000;
    @(negedge clk);
    saved_we = 1'b0;
    check("R10 saved", saved_q, 32'h5000_0000);
    issue(4'hD, 32'h0, 32'h0, 1'b0, 1'b1, 4'd15);
    check("R10 R7 flags", {28'b0, flags_q}, 32'h5);
    check("R7 restore pulse", {31'b0, restore_q}, 32'h1);
    check("R7 still writes", {31'b0, wr_en_q}, 32'h1);
    issue(4'hD, 32'h0, 32'h7, 1'b1, 1'b0, 4'd2);
    check("R7 pulse ends", {31'b0, restore_q}, 32'h0);
    check("R8 flags held", {28'b0, flags_q}, 32'h5);
    check("R1 MOV value", result_q, 32'h7);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule